// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block reads a 4x4 hexadecimal key matrix. It drives four active-high column lines and samples four row lines. A pressed key joins one column to one row. While the machine is idle it drives every column high, so any press raises at least one row. When that happens it turns on one column at a time to find the key's column. It then records a 4-bit code for the key and waits, with all columns high again, until every row falls.

The machine is meant to run from a slow clock, about 1 Hz, so that each step can be seen on LEDs wired to its state output. The row lines must already be synchronized to the clock, or change slowly compared with it. The last code stays on `key_code` after the key is released, so a display driven from it stays steady. `key_valid` marks the cycles in which the key is still held.

Top module: `kp_scanner`

## Requirements
- R1: While idle, `state_out` is 0 and `col_out` is 4'b1111. The machine stays idle on every edge at which no row is high.
- R2: In idle, if any row input is high at a clock edge, the machine moves to the first scan state (`state_out` = 1) at that edge.
- R3: Scan state k (k = 0..3) has `state_out` = k+1 and drives only column k (`col_out` = 1 << k). The scan states are visited in increasing k, one per edge.
- R4: In a scan state, if any row is high at an edge, the machine moves to the hold state (`state_out` = 5) at that edge. It loads `key_code` from the active column c and the row r, using this map: rows 0..2 with column 3 give 0xA+r; row 3 gives 0x0, 0xF, 0xE for columns 0, 1, 2; otherwise the code is 3*r+c+1.
- R5: In the hold state, `col_out` is 4'b1111 and `key_valid` is 1. The machine stays in hold while any row is high and returns to idle at the first edge with no row high.
- R6: If no row is high at the edge that ends scan state 3, the machine returns to idle.
- R7: If several rows are high in the scanned column, the lowest-numbered row sets the code.
- R8: `key_valid` is 0 in every state other than hold. `key_code` keeps its value until the next key is located.
- R9: When `rst_n` is low at a clock edge, the machine goes to idle and `key_code` is cleared to 0 (synchronous, active-low reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock (slow, about 1 Hz on a board) |
| rst_n | input | 1 | Synchronous active-low reset |
| row_in | input | 4 | Row lines from the matrix, active high, bit r is row r |
| col_out | output | 4 | Column drive, active high, bit c is column c |
| key_code | output | 4 | Code of the last key located |
| key_valid | output | 1 | High while in the hold state |
| state_out | output | 3 | Current state code, for LEDs |

## Verification
The state output and the column drive change at the edge that follows the condition on the rows. The column lines are a direct decode of the state, so they are correct in the same cycle as the state. A key in column c therefore reaches hold c+2 edges after the press, and the code and valid flag are due together with that hold state. A release reaches idle one edge later. The bench builds the row lines from a model of the pressed switches and the live column drive. It changes inputs and samples outputs only on falling edges, one rising edge apart, and compares each step against a count of edges worked out from the key's column and row.

// File: rtl/kp_pkg.sv
// Shared types and the key map of the matrix keypad scanner.
// Assumes a 4x4 matrix with rows and columns numbered 0..3.
package kp_pkg;

    // State codes; the numbers are visible on state_out.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SCAN0 = 3'd1,
        ST_SCAN1 = 3'd2,
        ST_SCAN2 = 3'd3,
        ST_SCAN3 = 3'd4,
        ST_HOLD  = 3'd5
    } kp_state_e;

    // Key code for a row/column crossing.
    function automatic logic [3:0] kp_key_code(input logic [1:0] row, input logic [1:0] col);
        logic [3:0] code;
        case (row)
            2'd0:    code = (col == 2'd3) ? 4'hA : 4'(col) + 4'd1;
            2'd1:    code = (col == 2'd3) ? 4'hB : 4'(col) + 4'd4;
            2'd2:    code = (col == 2'd3) ? 4'hC : 4'(col) + 4'd7;
            default: begin
                case (col)
                    2'd0:    code = 4'h0;
                    2'd1:    code = 4'hF;
                    2'd2:    code = 4'hE;
                    default: code = 4'hD;
                endcase
            end
        endcase
        return code;
    endfunction

endpackage

// File: rtl/kp_row_priority.sv
// Priority encoder over the row lines.
// Reports whether any row is high and the index of the lowest high row.
// Assumes the row lines are stable within a clock cycle.
module kp_row_priority #(
    parameter int ROWS = 4,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic [ROWS-1:0] rows,
    output logic            any_row,
    output logic [RW-1:0]   row_idx
);

    // OR of all rows: a key is down somewhere in the driven columns.
    assign any_row = |rows;

    // Lowest-numbered high row wins; scan from the top so the low one is last.
    always_comb begin
        row_idx = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (rows[r]) row_idx = RW'(r);
        end
    end

endmodule

// File: rtl/kp_scan_fsm.sv
// Sequencing machine of the keypad scanner: idle, four column scans, hold.
// Assumes any_row is the OR of the synchronized row lines.
// Synchronous active-low reset; unused state codes fall back to idle.
module kp_scan_fsm
    import kp_pkg::*;
#(
    parameter int COLS = 4,
    localparam int CW  = $clog2(COLS)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      any_row,
    output kp_state_e state,
    output logic      scanning,
    output logic [CW-1:0] scan_col,
    output logic      load_code
);

    kp_state_e state_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state choice from the current state and the row OR.
    always_comb begin
        case (state)
            ST_IDLE:  state_nx = any_row ? ST_SCAN0 : ST_IDLE;
            ST_SCAN0,
            ST_SCAN1,
            ST_SCAN2: state_nx = any_row ? ST_HOLD : kp_state_e'(state + 3'd1);
            ST_SCAN3: state_nx = any_row ? ST_HOLD : ST_IDLE;
            ST_HOLD:  state_nx = any_row ? ST_HOLD : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Scan flags: which column is active and whether the code is captured.
    always_comb begin
        scanning  = (state >= ST_SCAN0) && (state <= ST_SCAN3);
        scan_col  = CW'(state - 3'd1);
        load_code = scanning && any_row;
    end

endmodule

// File: rtl/kp_col_drive.sv
// Column line driver: all columns high outside scanning, one column while scanning.
// Assumes scan_col is meaningful only when scanning is high.
module kp_col_drive #(
    parameter int COLS = 4,
    localparam int CW  = $clog2(COLS)
) (
    input  logic            scanning,
    input  logic [CW-1:0]   scan_col,
    output logic [COLS-1:0] cols
);

    // One decode per column line.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign cols[c] = !scanning || (scan_col == CW'(c));
    end

endmodule

// File: rtl/kp_scanner.sv
// Top of the 4x4 matrix keypad scanner.
// Finds a press with all columns driven, locates it column by column,
// holds the code until release. Rows must be synchronized to clk.
module kp_scanner
    import kp_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] row_in,
    output logic [COLS-1:0] col_out,
    output logic [3:0]      key_code,
    output logic            key_valid,
    output logic [2:0]      state_out
);

    logic          any_row;
    logic [RW-1:0] row_idx;
    kp_state_e     state;
    logic          scanning;
    logic [CW-1:0] scan_col;
    logic          load_code;

    kp_row_priority #(.ROWS(ROWS)) u_rows (
        .rows    (row_in),
        .any_row (any_row),
        .row_idx (row_idx)
    );

    kp_scan_fsm #(.COLS(COLS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_row   (any_row),
        .state     (state),
        .scanning  (scanning),
        .scan_col  (scan_col),
        .load_code (load_code)
    );

    kp_col_drive #(.COLS(COLS)) u_cols (
        .scanning (scanning),
        .scan_col (scan_col),
        .cols     (col_out)
    );

    // Code register: loaded when a key is located, kept otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         key_code <= 4'h0;
        else if (load_code) key_code <= kp_key_code(2'(row_idx), 2'(scan_col));
    end

    // Status outputs taken from the state register.
    assign key_valid = (state == ST_HOLD);
    assign state_out = state;

endmodule

// File: rtl/kp_scanner_chk.sv
// Property checker for kp_scanner, attached with bind below.
module kp_scanner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] row_in,
    input logic [3:0] col_out,
    input logic [3:0] key_code,
    input logic       key_valid,
    input logic [2:0] state_out
);

    // R2
    idle_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_out == 3'd0 && row_in != 4'd0) |=> state_out == 3'd1);

    // R3
    scan_onecol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_out >= 3'd1 && state_out <= 3'd4) |-> $countones(col_out) == 1);

    // R5
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_out == 3'd5 && row_in == 4'd0) |=> state_out == 3'd0);

    // R5
    hold_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> col_out == 4'hF);

    // R6
    scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_out == 3'd4 && row_in == 4'd0) |=> state_out == 3'd0);

    // R8
    code_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_code) |-> state_out == 3'd5);

endmodule

bind kp_scanner kp_scanner_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_in    (row_in),
    .col_out   (col_out),
    .key_code  (key_code),
    .key_valid (key_valid),
    .state_out (state_out)
);

// File: tb/kp_scanner_bench.sv
// Bench for kp_scanner: a switch-matrix model, sweeps of all 16 keys,
// multi-key, early release and reset cases.
module kp_scanner_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] row_in;
    logic [3:0] col_out;
    logic [3:0] key_code;
    logic       key_valid;
    logic [2:0] state_out;
    logic [15:0] keys = '0;   // bit r*4+c = switch at row r, column c closed
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // Switch matrix model: a row is high when a closed switch meets a driven column.
    always_comb begin
        for (int r = 0; r < 4; r++) row_in[r] = |(keys[r*4 +: 4] & col_out);
    end

    kp_scanner u_kp_scanner (
        .clk(clk), .rst_n(rst_n), .row_in(row_in), .col_out(col_out),
        .key_code(key_code), .key_valid(key_valid), .state_out(state_out)
    );

    function automatic int exp_code(int r, int c);
        if (c == 3) return 10 + r;
        if (r == 3) return (c == 0) ? 0 : 16 - c;
        return 3 * r + c + 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk_idle(string req);
        chk({req, " state"}, state_out, 0);
        chk({req, " cols"}, col_out, 15);
        chk({req, " valid"}, key_valid, 0);
    endtask

    task automatic chk_hold(string req, int code);
        chk({req, " state"}, state_out, 5);
        chk({req, " cols"}, col_out, 15);
        chk({req, " valid"}, key_valid, 1);
        chk({req, " code"}, key_code, code);
    endtask

    // One key press from idle to release; c+2 edges to reach hold.
    task automatic press_one(int r, int c);
        keys = 16'(1) << (r * 4 + c);
        for (int k = 0; k <= c; k++) begin
            tick();
            chk("R3 scan state", state_out, k + 1);
            chk("R3 scan column", col_out, 1 << k);
            chk("R8 valid low in scan", key_valid, 0);
        end
        tick();
        chk_hold("R4", exp_code(r, c));
        tick();
        chk_hold("R5 stays", exp_code(r, c));
        keys = '0;
        tick();
        chk_idle("R5 release");
        chk("R8 code kept", key_code, exp_code(r, c));
        tick();
        chk_idle("R1 stays idle");
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        tick();
        tick();
        chk_idle("R9 reset");
        chk("R9 code cleared", key_code, 0);
        rst_n = 1'b1;
        tick();
        chk_idle("R1 idle no key");

        // R2, R3, R4, R5, R8: every key of the matrix.
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) press_one(r, c);

        // R2: first edge after a press.
        keys = 16'(1) << 5;
        tick();
        chk("R2 press to scan0", state_out, 1);
        tick();
        tick();
        chk("R4 key 5", key_code, 5);
        keys = '0;
        tick();

        // R7: rows 1 and 2 in column 2 -> row 1 wins, code 6.
        keys = (16'(1) << 6) | (16'(1) << 10);
        repeat (4) tick();
        chk_hold("R7 lowest row", 6);
        keys = '0;
        tick();

        // R7: all four rows in column 1 -> row 0, code 2.
        keys = 16'h2222;
        repeat (3) tick();
        chk_hold("R7 all rows", 2);
        keys = '0;
        tick();

        // R3: keys at (2,0) and (0,3): column 0 is scanned first, code 7.
        keys = (16'(1) << 8) | (16'(1) << 3);
        repeat (2) tick();
        chk_hold("R3 scan order", 7);
        keys = '0;
        tick();

        // R6: release right after detection; scans run out then idle.
        keys = 16'(1) << 15;
        tick();
        chk("R6 scan0", state_out, 1);
        keys = '0;
        tick();
        tick();
        tick();
        chk("R6 scan3", state_out, 4);
        tick();
        chk_idle("R6 back to idle");
        chk("R8 code after empty scan", key_code, 7);

        // R9: reset while holding.
        keys = 16'(1) << 12;
        repeat (2) tick();
        chk_hold("R4 key 0", 0);
        keys = 16'(1) << 13;
        rst_n = 1'b0;
        tick();
        chk_idle("R9 reset in hold");
        chk("R9 code cleared in hold", key_code, 0);
        keys = '0;
        rst_n = 1'b1;
        tick();
        chk_idle("R9 after reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule